// File: doc/BRIEF.md
# Two-Group Conversion Sequencer

This block decides which analog channel a converter front end samples next. Two request groups share one modulator. The regular group converts a single programmed channel each time it is triggered and never scans. The injected group converts every channel selected in a bitmask, one after another, starting from the lowest set bit. The injected group wins whenever both groups are waiting at a conversion boundary. A conversion that has already started is never interrupted.

Each group has its own triggers. The regular group starts from a software start bit or a sync pulse from a master instance. The injected group starts from a software start bit, a timer event, an external pin or a master sync pulse. Each group has its own busy flag, end-of-conversion flag and overrun flag. The four event flags are cleared by writing 1 and are gated into interrupt requests by enable bits.

The modulator is driven through a plain handshake. The sequencer pulses `conv_start` with the channel on `conv_chan`. The modulator then returns a one-cycle `conv_done` pulse when the result is ready.

Top module: `rij_conv_seq`

## Requirements
- R1: After synchronous reset, all flags, interrupts, busy flags, start bits, `conv_start` and `conv_active` are 0.
- R2: A software start write to an idle group sets that group's start bit on the next cycle. The bit reads 1 for exactly one cycle and then clears itself. A write made while the group is busy leaves the bit at 0.
- R3: A regular trigger, by software bit or by `reg_sync`, latches `reg_chan` and sets `reg_busy`. Exactly one conversion of that channel follows, and `reg_busy` drops when it completes. A trigger with `reg_chan` ≥ NCH is ignored.
- R4: Any injected trigger (software bit, `inj_timer`, `inj_pin`, `inj_sync`) with a nonzero `inj_mask` latches the mask. Each set bit is then converted once, lowest index first, and `inj_busy` is held until the last one completes. A trigger with a zero mask is ignored.
- R5: A trigger to a group that is already busy causes no extra conversion.
- R6: When both groups wait at a conversion boundary, the injected channels are started first. A running conversion is never preempted.
- R7: `flags[0]` (regular EOC) is set when a regular conversion completes. `flags[1]` (injected EOC) is set when each injected channel completes.
- R8: `flags[2]` (regular overrun) and `flags[3]` (injected overrun) are set when that group completes a conversion while its EOC flag is still set and not being cleared in the same cycle.
- R9: Writing 1 to bit i of `flag_clr` clears `flags[i]`. A set event in the same cycle wins.
- R10: `irq[i]` equals `flags[i]` AND the `irq_en[i]` value sampled at the same edge, aligned with the flags.
- R11: `conv_start` is a one-cycle pulse on the cycle `conv_active` rises. `conv_chan` stays below NCH and holds steady while `conv_active` is 1. `conv_inj` marks an injected conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sw_wr | input | 1 | Software write of the regular start bit |
| reg_sync | input | 1 | Regular trigger from master instance |
| reg_chan | input | CHW | Regular channel number |
| inj_sw_wr | input | 1 | Software write of the injected start bit |
| inj_timer | input | 1 | Injected timer trigger |
| inj_pin | input | 1 | Injected external pin trigger |
| inj_sync | input | 1 | Injected trigger from master instance |
| inj_mask | input | NCH | Injected channel selection, bit i = channel i |
| conv_done | input | 1 | Modulator reports result ready |
| flag_clr | input | 4 | Write-1-to-clear for flags |
| irq_en | input | 4 | Interrupt enables per flag |
| conv_start | output | 1 | Start pulse to modulator |
| conv_active | output | 1 | Conversion in progress |
| conv_inj | output | 1 | Current conversion belongs to injected group |
| conv_chan | output | CHW | Channel being converted |
| reg_busy | output | 1 | Regular conversion requested or running |
| inj_busy | output | 1 | Injected sequence requested or running |
| reg_sw_bit | output | 1 | Regular software start bit readback |
| inj_sw_bit | output | 1 | Injected software start bit readback |
| flags | output | 4 | {inj overrun, reg overrun, inj EOC, reg EOC} |
| irq | output | 4 | Interrupt requests, one per flag |

## Verification
Single regular conversions are driven by software and by sync on different channels, which shows that the latched channel, not a fixed one, reaches the modulator. Injected masks with sparse bits (2, 5, 8), with adjacent bits and with no bits separate the lowest-first scan from plain index order and from the empty case. Injected and regular requests are overlapped in both orders to tell boundary priority apart from preemption. Repeated completions without clearing, followed by partial clears under partial enables, separate the overrun, clear and interrupt gating paths.

// File: rtl/rij_pkg.sv
package rij_pkg;
  localparam int NFLAG    = 4;
  localparam int F_REOC   = 0;
  localparam int F_IEOC   = 1;
  localparam int F_ROVR   = 2;
  localparam int F_IOVR   = 3;
endpackage

// File: rtl/rij_trig_gate.sv
module rij_trig_gate #(
  parameter int NHW = 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           sw_wr,
  input  logic [NHW-1:0] hw_trig,
  input  logic           busy,
  output logic           sw_bit,
  output logic           fire
);
  // start bit accepted only when the group is idle; lives one cycle
  always_ff @(posedge clk) begin
    if (rst) sw_bit <= 1'b0;
    else     sw_bit <= sw_wr && !busy && !sw_bit;
  end

  assign fire = sw_bit || (|hw_trig);
endmodule

// File: rtl/rij_lsb_pick.sv
module rij_lsb_pick #(
  parameter int N   = 9,
  parameter int IW  = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          hit,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  oh
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    oh  = '0;
    for (int i = 0; i < N; i++) begin
      if (!hit && req[i]) begin
        hit   = 1'b1;
        idx   = IW'(i);
        oh[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rij_flag_bank.sv
module rij_flag_bank #(
  parameter int NF = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NF-1:0] set,
  input  logic [NF-1:0] clr,
  input  logic [NF-1:0] en,
  output logic [NF-1:0] flags,
  output logic [NF-1:0] irq
);
  logic [NF-1:0] nxt;

  always_comb nxt = (flags & ~clr) | set;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      irq   <= '0;
    end else begin
      flags <= nxt;
      irq   <= nxt & en;
    end
  end
endmodule

// File: rtl/rij_conv_seq.sv
module rij_conv_seq
  import rij_pkg::*;
#(
  parameter int NCH = 9,
  parameter int CHW = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_sw_wr,
  input  logic             reg_sync,
  input  logic [CHW-1:0]   reg_chan,
  input  logic             inj_sw_wr,
  input  logic             inj_timer,
  input  logic             inj_pin,
  input  logic             inj_sync,
  input  logic [NCH-1:0]   inj_mask,
  input  logic             conv_done,
  input  logic [NFLAG-1:0] flag_clr,
  input  logic [NFLAG-1:0] irq_en,
  output logic             conv_start,
  output logic             conv_active,
  output logic             conv_inj,
  output logic [CHW-1:0]   conv_chan,
  output logic             reg_busy,
  output logic             inj_busy,
  output logic             reg_sw_bit,
  output logic             inj_sw_bit,
  output logic [NFLAG-1:0] flags,
  output logic [NFLAG-1:0] irq
);
  logic           reg_fire, inj_fire;
  logic [CHW-1:0] reg_lat;
  logic [NCH-1:0] inj_left, cur_oh;
  logic           pick_hit;
  logic [CHW-1:0] pick_idx;
  logic [NCH-1:0] pick_oh;
  logic           reg_ok, inj_ok;
  logic           done_reg, done_inj;
  logic [NFLAG-1:0] fset;

  rij_trig_gate #(.NHW(1)) u_reg_gate (
    .clk(clk), .rst(rst), .sw_wr(reg_sw_wr), .hw_trig(reg_sync),
    .busy(reg_busy), .sw_bit(reg_sw_bit), .fire(reg_fire)
  );

  rij_trig_gate #(.NHW(3)) u_inj_gate (
    .clk(clk), .rst(rst), .sw_wr(inj_sw_wr),
    .hw_trig({inj_sync, inj_pin, inj_timer}),
    .busy(inj_busy), .sw_bit(inj_sw_bit), .fire(inj_fire)
  );

  rij_lsb_pick #(.N(NCH), .IW(CHW)) u_pick (
    .req(inj_left), .hit(pick_hit), .idx(pick_idx), .oh(pick_oh)
  );

  assign reg_ok = reg_fire && !reg_busy && (int'(reg_chan) < NCH);
  assign inj_ok = inj_fire && !inj_busy && (|inj_mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_busy    <= 1'b0;
      inj_busy    <= 1'b0;
      reg_lat     <= '0;
      inj_left    <= '0;
      cur_oh      <= '0;
      conv_start  <= 1'b0;
      conv_active <= 1'b0;
      conv_inj    <= 1'b0;
      conv_chan   <= '0;
    end else begin
      conv_start <= 1'b0;
      if (reg_ok) begin
        reg_busy <= 1'b1;
        reg_lat  <= reg_chan;
      end
      if (inj_ok) begin
        inj_busy <= 1'b1;
        inj_left <= inj_mask;
      end
      if (conv_active) begin
        if (conv_done) begin
          conv_active <= 1'b0;
          if (conv_inj) begin
            inj_left <= inj_left & ~cur_oh;
            if ((inj_left & ~cur_oh) == '0) inj_busy <= 1'b0;
          end else begin
            reg_busy <= 1'b0;
          end
        end
      end else if (inj_busy && pick_hit) begin
        conv_start  <= 1'b1;
        conv_active <= 1'b1;
        conv_inj    <= 1'b1;
        conv_chan   <= pick_idx;
        cur_oh      <= pick_oh;
      end else if (reg_busy) begin
        conv_start  <= 1'b1;
        conv_active <= 1'b1;
        conv_inj    <= 1'b0;
        conv_chan   <= reg_lat;
      end
    end
  end

  assign done_reg = conv_active && conv_done && !conv_inj;
  assign done_inj = conv_active && conv_done &&  conv_inj;

  always_comb begin
    fset         = '0;
    fset[F_REOC] = done_reg;
    fset[F_IEOC] = done_inj;
    fset[F_ROVR] = done_reg && flags[F_REOC] && !flag_clr[F_REOC];
    fset[F_IOVR] = done_inj && flags[F_IEOC] && !flag_clr[F_IEOC];
  end

  rij_flag_bank #(.NF(NFLAG)) u_flags (
    .clk(clk), .rst(rst), .set(fset), .clr(flag_clr), .en(irq_en),
    .flags(flags), .irq(irq)
  );
endmodule

// File: rtl/rij_conv_seq_chk.sv
module rij_conv_seq_chk #(
  parameter int NCH = 9,
  parameter int CHW = $clog2(NCH)
) (
  input logic           clk,
  input logic           rst,
  input logic           conv_start,
  input logic           conv_active,
  input logic           conv_inj,
  input logic [CHW-1:0] conv_chan,
  input logic           reg_busy,
  input logic           inj_busy,
  input logic           reg_sw_bit,
  input logic           inj_sw_bit,
  input logic [3:0]     flags,
  input logic [3:0]     irq,
  input logic [3:0]     irq_en
);
  assert_start_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> $rose(conv_active));
  assert_chan_range_R11: assert property (@(posedge clk) disable iff (rst)
    conv_active |-> (int'(conv_chan) < NCH));
  assert_chan_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (conv_active && $past(conv_active)) |-> $stable(conv_chan));
  assert_inj_first_R6: assert property (@(posedge clk) disable iff (rst)
    (conv_start && !conv_inj) |-> !$past(inj_busy));
  assert_reg_swbit_R2: assert property (@(posedge clk) disable iff (rst)
    reg_sw_bit |=> !reg_sw_bit);
  assert_inj_swbit_R2: assert property (@(posedge clk) disable iff (rst)
    inj_sw_bit |=> !inj_sw_bit);
  assert_reg_ovr_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(flags[2]) |-> $past(flags[0]));
  assert_inj_ovr_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(flags[3]) |-> $past(flags[1]));
  assert_irq_gate_R10: assert property (@(posedge clk) disable iff (rst)
    irq == (flags & $past(irq_en)));
  assert_reg_busy_R3: assert property (@(posedge clk) disable iff (rst)
    (conv_active && !conv_inj) |-> reg_busy);
  assert_inj_busy_R4: assert property (@(posedge clk) disable iff (rst)
    (conv_active && conv_inj) |-> inj_busy);
endmodule

bind rij_conv_seq rij_conv_seq_chk #(.NCH(NCH), .CHW(CHW)) u_chk (
  .clk(clk), .rst(rst), .conv_start(conv_start), .conv_active(conv_active),
  .conv_inj(conv_inj), .conv_chan(conv_chan), .reg_busy(reg_busy),
  .inj_busy(inj_busy), .reg_sw_bit(reg_sw_bit), .inj_sw_bit(inj_sw_bit),
  .flags(flags), .irq(irq), .irq_en(irq_en)
);

// File: tb/rij_conv_seq_tb.sv
module rij_conv_seq_tb;
  localparam int NCH = 9;
  localparam int CHW = $clog2(NCH);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_sw_wr = 0, reg_sync = 0, inj_sw_wr = 0, inj_timer = 0, inj_pin = 0, inj_sync = 0;
  logic [CHW-1:0] reg_chan = '0;
  logic [NCH-1:0] inj_mask = '0;
  logic conv_done = 0;
  logic [3:0] flag_clr = '0, irq_en = '0;
  logic conv_start, conv_active, conv_inj, reg_busy, inj_busy, reg_sw_bit, inj_sw_bit;
  logic [CHW-1:0] conv_chan;
  logic [3:0] flags, irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  rij_conv_seq #(.NCH(NCH)) u_dut (
    .clk(clk), .rst(rst), .reg_sw_wr(reg_sw_wr), .reg_sync(reg_sync), .reg_chan(reg_chan),
    .inj_sw_wr(inj_sw_wr), .inj_timer(inj_timer), .inj_pin(inj_pin), .inj_sync(inj_sync),
    .inj_mask(inj_mask), .conv_done(conv_done), .flag_clr(flag_clr), .irq_en(irq_en),
    .conv_start(conv_start), .conv_active(conv_active), .conv_inj(conv_inj),
    .conv_chan(conv_chan), .reg_busy(reg_busy), .inj_busy(inj_busy),
    .reg_sw_bit(reg_sw_bit), .inj_sw_bit(inj_sw_bit), .flags(flags), .irq(irq)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
  endtask

  task automatic wait_start(input string req);
    bit seen = 0;
    for (int i = 0; i < 40; i++) begin
      if (conv_start) begin seen = 1; break; end
      @(negedge clk);
    end
    chk(req, "conv_start seen", int'(seen), 1);
  endtask

  task automatic finish_conv();
    repeat (3) @(negedge clk);
    conv_done = 1'b1;
    @(negedge clk); conv_done = 1'b0;
  endtask

  task automatic serve(input int ch, input int inj, input string req);
    wait_start(req);
    chk(req, "conv_chan", int'(conv_chan), ch);
    chk(req, "conv_inj", int'(conv_inj), inj);
    @(negedge clk);
    chk("R11", "start is one cycle", int'(conv_start), 0);
    finish_conv();
  endtask

  task automatic expect_quiet(input int n, input string req);
    int starts = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (conv_start) starts++;
    end
    chk(req, "no extra conversion", starts, 0);
  endtask

  task automatic clear_all();
    @(negedge clk); flag_clr = 4'hF;
    @(negedge clk); flag_clr = 4'h0;
  endtask

  task automatic t_reset();
    chk("R1", "flags", int'(flags), 0);
    chk("R1", "irq", int'(irq), 0);
    chk("R1", "busy", int'({reg_busy, inj_busy, conv_active, conv_start}), 0);
    chk("R1", "sw bits", int'({reg_sw_bit, inj_sw_bit}), 0);
  endtask

  task automatic t_reg_sw();
    reg_chan = 4'd5;
    @(negedge clk); reg_sw_wr = 1'b1;
    @(negedge clk); reg_sw_wr = 1'b0;
    chk("R2", "start bit set", int'(reg_sw_bit), 1);
    @(negedge clk);
    chk("R2", "start bit self-clears", int'(reg_sw_bit), 0);
    chk("R3", "reg_busy after accept", int'(reg_busy), 1);
    reg_chan = 4'd2;
    serve(5, 0, "R3");
    chk("R3", "reg_busy dropped", int'(reg_busy), 0);
    chk("R7", "regular EOC", int'(flags), 4'b0001);
  endtask

  task automatic t_reg_ovr_irq();
    irq_en = 4'b0101;
    reg_chan = 4'd8;
    pulse(reg_sync);
    serve(8, 0, "R3");
    chk("R8", "regular overrun", int'(flags), 4'b0101);
    chk("R10", "irq gated", int'(irq), 4'b0101);
    @(negedge clk); flag_clr = 4'b0001;
    @(negedge clk); flag_clr = 4'b0000;
    chk("R9", "EOC cleared only", int'(flags), 4'b0100);
    chk("R10", "irq follows clear", int'(irq), 4'b0100);
    irq_en = 4'b0000;
    @(negedge clk);
    chk("R10", "irq off with enable", int'(irq), 0);
    clear_all();
    chk("R9", "all cleared", int'(flags), 0);
  endtask

  task automatic t_reg_bad_chan();
    reg_chan = 4'd12;
    pulse(reg_sync);
    @(negedge clk);
    chk("R3", "out-of-range channel ignored", int'(reg_busy), 0);
    expect_quiet(8, "R3");
  endtask

  task automatic t_reg_busy_ignore();
    reg_chan = 4'd3;
    pulse(reg_sync);
    wait_start("R5");
    chk("R5", "first channel", int'(conv_chan), 3);
    reg_chan = 4'd6;
    pulse(reg_sync);
    @(negedge clk); reg_sw_wr = 1'b1;
    @(negedge clk); reg_sw_wr = 1'b0;
    chk("R2", "start bit ignored while busy", int'(reg_sw_bit), 0);
    finish_conv();
    chk("R5", "reg idle after one", int'(reg_busy), 0);
    expect_quiet(10, "R5");
    clear_all();
  endtask

  task automatic t_inj_scan();
    inj_mask = 9'b1_0010_0100;
    pulse(inj_timer);
    chk("R4", "inj_busy", int'(inj_busy), 1);
    inj_mask = 9'b0_0000_0001;
    serve(2, 1, "R4");
    chk("R4", "inj_busy mid-scan", int'(inj_busy), 1);
    serve(5, 1, "R4");
    chk("R8", "injected overrun", int'(flags), 4'b1010);
    serve(8, 1, "R4");
    chk("R4", "inj_busy done", int'(inj_busy), 0);
    chk("R7", "injected EOC", int'(flags[1]), 1);
    expect_quiet(8, "R4");
    clear_all();
  endtask

  task automatic t_inj_sw_zero();
    inj_mask = '0;
    pulse(inj_sync);
    @(negedge clk);
    chk("R4", "zero mask ignored", int'(inj_busy), 0);
    expect_quiet(6, "R4");
    inj_mask = 9'b0_0000_0110;
    @(negedge clk); inj_sw_wr = 1'b1;
    @(negedge clk); inj_sw_wr = 1'b0;
    chk("R2", "inj start bit set", int'(inj_sw_bit), 1);
    @(negedge clk);
    chk("R2", "inj start bit clears", int'(inj_sw_bit), 0);
    serve(1, 1, "R4");
    serve(2, 1, "R4");
    clear_all();
  endtask

  task automatic t_priority();
    inj_mask = 9'b0_0000_0101;
    reg_chan = 4'd7;
    @(negedge clk); inj_timer = 1'b1;
    @(negedge clk); inj_timer = 1'b0; reg_sync = 1'b1;
    @(negedge clk); reg_sync = 1'b0;
    serve(0, 1, "R6");
    chk("R6", "regular still waiting", int'(reg_busy), 1);
    serve(2, 1, "R6");
    serve(7, 0, "R6");
    clear_all();
    reg_chan = 4'd4;
    inj_mask = 9'b0_0000_0010;
    pulse(reg_sw_wr);
    wait_start("R6");
    chk("R6", "regular running", int'(conv_chan), 4);
    pulse(inj_pin);
    chk("R6", "not preempted", int'({conv_active, conv_inj}), 2);
    chk("R6", "injected pending", int'(inj_busy), 1);
    finish_conv();
    serve(1, 1, "R6");
    clear_all();
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d expected below %0d", cyc, 20000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_reg_sw();
    t_reg_ovr_irq();
    t_reg_bad_chan();
    t_reg_busy_ignore();
    t_inj_scan();
    t_inj_sw_zero();
    t_priority();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule